// File: doc/BRIEF.md
# AUX Channel Request Framer

This block turns one access request on a display sideband channel into a byte stream, hands the stream to a lower transport, and acts on what the transport reports back. There are four kinds of access: native read, native write, I2C read and I2C write. An I2C access may also be address-only, and it may leave the I2C transaction open by clearing the stop flag. The block builds a four-byte header, adds the write payload where the access has one, and sends the bytes one at a time with a valid/ready handshake. It then waits for a single response beat that carries a transport status, a reply byte and a received-byte count.

The reply byte is decoded in two levels. The native field comes first. The I2C field is looked at only when the access is an I2C access and the native field says ACK. A busy transport is retried on the next cycle. A deferral on either level is retried after a pause of about 400 microseconds, timed by a cycle counter derived from the clock frequency parameter. Every other outcome ends the request. The number of attempts is bounded. The end of a request is marked by a one-cycle done pulse that carries a result code and the clipped count of received bytes.

Top module: `aux_req_framer`

## Requirements
- R1: Header byte 0 is address bits 7:0 and byte 1 is address bits 15:8. Byte 2 holds the command nibble in bits 7:4 and address bits 19:16 in bits 3:0. The command nibble is 8 for native write, 9 for native read, 0 for I2C write and 1 for I2C read, plus 4 on an I2C access whose stop input is 0.
- R2: Byte 3 and the frame size depend on the access. A native write sends 4+len bytes, with byte 3 = ((4+len)·16 mod 256) + len−1, followed by the payload bytes with wr_data[7:0] first. A native read sends 4 bytes, with byte 3 = 0x40 + len−1. An I2C write sends 5 bytes, with byte 3 = 0x50 and byte 4 = wr_data[7:0]. An I2C read sends 4 bytes with byte 3 = 0x40. An address-only I2C access sends 4 bytes with byte 3 = 0x30. tx_last marks the final byte, and a byte counts as sent only in a cycle with tx_ready high.
- R3: A native write with length 0 or length above MAX_PAYLOAD sends no byte. done rises in the cycle after start with result 5 (rejected).
- R4: Transport status 1 (timeout) ends the request with result 1. Status 3 (error) ends it with result 2. Status 2 (busy) starts sending the frame again in the very next cycle. Status 0 means the reply byte is valid.
- R5: The native reply field is rsp_reply[5:4]: 0 is ACK, 2 is DEFER, and 1 (NACK) or 3 (unknown) ends the request with result 3.
- R6: The I2C reply field rsp_reply[7:6] uses the same code values. It is acted on only for I2C accesses whose native field is ACK. For native accesses it is ignored, and so is any I2C field that comes with a native DEFER.
- R7: After a DEFER on either level, the first byte of the next attempt appears exactly WAIT_CYC = CLK_HZ/2500 cycles (at least 1) after the response cycle.
- R8: At most MAX_TRIES attempts are made. If a busy or DEFER response arrives on the last attempt, the request ends with result 6 in the next cycle, without a pause.
- R9: On a final ACK, rx_count is min(rsp_len, buf_cap) with buf_cap taken at start, and a native write reports 0. A native read acknowledged with rsp_len 0 ends with result 4 (protocol error).
- R10: done is a one-cycle pulse in the cycle after the response that ends the request. Result codes: 0 ok, 1 timeout, 2 transport error, 3 refused, 4 protocol, 5 rejected, 6 attempts used up.
- R11: Out of reset, tx_valid and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, taken while idle |
| req_kind | input | 2 | 0 native write, 1 native read, 2 I2C write, 3 I2C read |
| addr_only | input | 1 | I2C access without data |
| stop | input | 1 | End the I2C transaction after this access |
| req_addr | input | 20 | Target address |
| req_len | input | LEN_W | Data length in bytes |
| buf_cap | input | LEN_W | Receive buffer size of the requester |
| wr_data | input | MAX_PAYLOAD*8 | Write payload, byte 0 in bits 7:0 |
| tx_valid | output | 1 | Frame byte valid |
| tx_byte | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Transport accepts the byte |
| rsp_valid | input | 1 | Response beat |
| rsp_status | input | 2 | Transport status |
| rsp_reply | input | 8 | Reply byte |
| rsp_len | input | LEN_W | Bytes received by the transport |
| done | output | 1 | Request finished (one cycle) |
| result | output | 3 | Result code |
| rx_count | output | LEN_W | Clipped received count |

## Verification
The hardest cases to reach from the ports are the retry paths that end on the final attempt. To get there, a chain of busy or deferring responses has to be answered only after each complete frame, and a real wait has to pass between deferrals. The bench acts as the transport. It answers each frame from a per-vector list of up to four responses. Between responses it counts the idle cycles before the next frame begins, so the immediate busy resend and the exact deferral pause are both measured. A deferral on the fourth attempt then shows whether the request stops there. Reply bytes that carry an I2C code on a native access, or alongside a native deferral, test the rule that the second decoding level is used only under a native ACK.

// File: rtl/aux_pkg.sv
package aux_pkg;
  localparam int AUX_ADDR_W = 20;

  typedef enum logic [1:0] {
    K_NWR = 2'd0, K_NRD = 2'd1, K_IWR = 2'd2, K_IRD = 2'd3
  } req_kind_e;

  typedef enum logic [2:0] {
    R_OK = 3'd0, R_TIMEOUT = 3'd1, R_IO = 3'd2, R_NACK = 3'd3,
    R_PROTO = 3'd4, R_TOOLONG = 3'd5, R_RETRY = 3'd6
  } result_e;

  typedef enum logic [1:0] {
    RC_ACK = 2'd0, RC_NACK = 2'd1, RC_DEFER = 2'd2, RC_BAD = 2'd3
  } reply_e;

  typedef enum logic [1:0] {
    XS_DONE = 2'd0, XS_TIMEOUT = 2'd1, XS_BUSY = 2'd2, XS_ERR = 2'd3
  } xport_e;

  // command nibble: native = 100r, i2c = 0m0r (m = transaction stays open)
  function automatic logic [3:0] cmd_code(req_kind_e k, logic stop_i);
    if (!k[1]) return {3'b100, k[0]};
    return {1'b0, ~stop_i, 1'b0, k[0]};
  endfunction

  function automatic logic [7:0] frame_bytes(req_kind_e k, logic aonly, logic [7:0] len);
    case (k)
      K_NWR:   return 8'd4 + len;
      K_IWR:   return aonly ? 8'd4 : 8'd5;
      default: return 8'd4;
    endcase
  endfunction

  function automatic logic [7:0] size_code(req_kind_e k, logic aonly, logic [7:0] len);
    logic [7:0] m;
    m = frame_bytes(k, aonly, len);
    if (!k[1]) return {m[3:0], len[3:0] - 4'd1};
    if (aonly) return 8'h30;
    return {m[3:0], 4'h0};
  endfunction
endpackage

// File: rtl/aux_reply_decode.sv
module aux_reply_decode
  import aux_pkg::*;
(
  input  logic       i2c_cmd,
  input  logic [7:0] reply,
  output reply_e     code
);
  always_comb begin
    if (reply[5:4] != 2'b00)  code = reply_e'(reply[5:4]);
    else if (i2c_cmd)         code = reply_e'(reply[7:6]);
    else                      code = RC_ACK;
  end
endmodule

// File: rtl/aux_frame_mux.sv
module aux_frame_mux
  import aux_pkg::*;
#(
  parameter int MAX_PAYLOAD = 16,
  parameter int IDX_W       = 5
) (
  input  req_kind_e                kind,
  input  logic                     aonly,
  input  logic                     stop_i,
  input  logic [AUX_ADDR_W-1:0]    addr,
  input  logic [7:0]               len8,
  input  logic [MAX_PAYLOAD*8-1:0] payload,
  input  logic [IDX_W-1:0]         idx,
  output logic [7:0]               byte_o,
  output logic                     last_o
);
  localparam int PI_W = (MAX_PAYLOAD > 1) ? $clog2(MAX_PAYLOAD) : 1;

  logic [7:0]      total;
  logic [PI_W-1:0] pidx;

  always_comb begin
    total  = frame_bytes(kind, aonly, len8);
    last_o = (int'(idx) == int'(total) - 1);
    pidx   = PI_W'(idx - IDX_W'(4));
    if (idx == IDX_W'(0))      byte_o = addr[7:0];
    else if (idx == IDX_W'(1)) byte_o = addr[15:8];
    else if (idx == IDX_W'(2)) byte_o = {cmd_code(kind, stop_i), addr[19:16]};
    else if (idx == IDX_W'(3)) byte_o = size_code(kind, aonly, len8);
    else                       byte_o = payload[pidx*8 +: 8];
  end
endmodule

// File: rtl/aux_wait_timer.sv
module aux_wait_timer #(
  parameter int CYC = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expire
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= CW'(CYC - 1);
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expire = (cnt == '0);
endmodule

// File: rtl/aux_req_framer.sv
module aux_req_framer
  import aux_pkg::*;
#(
  parameter int CLK_HZ      = 1_000_000,
  parameter int MAX_TRIES   = 4,
  parameter int MAX_PAYLOAD = 16,
  parameter int LEN_W       = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [1:0]               req_kind,
  input  logic                     addr_only,
  input  logic                     stop,
  input  logic [19:0]              req_addr,
  input  logic [LEN_W-1:0]         req_len,
  input  logic [LEN_W-1:0]         buf_cap,
  input  logic [MAX_PAYLOAD*8-1:0] wr_data,
  output logic                     tx_valid,
  output logic [7:0]               tx_byte,
  output logic                     tx_last,
  input  logic                     tx_ready,
  input  logic                     rsp_valid,
  input  logic [1:0]               rsp_status,
  input  logic [7:0]               rsp_reply,
  input  logic [LEN_W-1:0]         rsp_len,
  output logic                     done,
  output logic [2:0]               result,
  output logic [LEN_W-1:0]         rx_count
);
  localparam int WAIT_CYC = (CLK_HZ / 2500 < 1) ? 1 : CLK_HZ / 2500;
  localparam int TRY_W    = $clog2(MAX_TRIES + 1);
  localparam int IDX_W    = $clog2(MAX_PAYLOAD + 5);

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_RESP, ST_WAIT} state_e;

  state_e            st;
  req_kind_e         kind_q;
  logic              aonly_q, stop_q;
  logic [19:0]       addr_q;
  logic [LEN_W-1:0]  len_q, cap_q;
  logic [IDX_W-1:0]  idx_q;
  logic [TRY_W-1:0]  tries_q;
  logic              done_q;
  result_e           result_q;
  logic [LEN_W-1:0]  rx_q;

  // named internal events
  logic              too_long, frame_last, final_try, timer_expire;
  logic              in_idle, in_resp, in_wait;
  logic              ev_finish, ev_resend, ev_wait;
  result_e           ev_res;
  logic [LEN_W-1:0]  ev_cnt, clipped;
  reply_e            code;

  assign in_idle   = (st == ST_IDLE);
  assign in_resp   = (st == ST_RESP);
  assign in_wait   = (st == ST_WAIT);
  assign too_long  = (req_kind_e'(req_kind) == K_NWR) &&
                     ((req_len == '0) || (int'(req_len) > MAX_PAYLOAD));
  assign final_try = (int'(tries_q) == MAX_TRIES - 1);
  assign clipped   = (rsp_len < cap_q) ? rsp_len : cap_q;

  aux_frame_mux #(.MAX_PAYLOAD(MAX_PAYLOAD), .IDX_W(IDX_W)) u_mux (
    .kind(kind_q), .aonly(aonly_q), .stop_i(stop_q), .addr(addr_q),
    .len8(8'(len_q)), .payload(wr_data), .idx(idx_q),
    .byte_o(tx_byte), .last_o(frame_last)
  );

  aux_reply_decode u_dec (.i2c_cmd(kind_q[1]), .reply(rsp_reply), .code(code));

  aux_wait_timer #(.CYC(WAIT_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(ev_wait), .expire(timer_expire)
  );

  always_comb begin
    ev_finish = 1'b0;
    ev_resend = 1'b0;
    ev_wait   = 1'b0;
    ev_res    = R_OK;
    ev_cnt    = '0;
    if (in_resp && rsp_valid) begin
      case (xport_e'(rsp_status))
        XS_TIMEOUT: begin ev_finish = 1'b1; ev_res = R_TIMEOUT; end
        XS_ERR:     begin ev_finish = 1'b1; ev_res = R_IO; end
        XS_BUSY: begin
          if (final_try) begin ev_finish = 1'b1; ev_res = R_RETRY; end
          else ev_resend = 1'b1;
        end
        default: begin
          case (code)
            RC_ACK: begin
              ev_finish = 1'b1;
              if (kind_q == K_NRD && rsp_len == '0) ev_res = R_PROTO;
              else if (kind_q != K_NWR)             ev_cnt = clipped;
            end
            RC_DEFER: begin
              if (final_try) begin ev_finish = 1'b1; ev_res = R_RETRY; end
              else ev_wait = 1'b1;
            end
            default: begin ev_finish = 1'b1; ev_res = R_NACK; end
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;   kind_q <= K_NWR; aonly_q <= 1'b0; stop_q <= 1'b0;
      addr_q <= '0;    len_q <= '0;     cap_q <= '0;     idx_q <= '0;
      tries_q <= '0;   done_q <= 1'b0;  result_q <= R_OK; rx_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          kind_q  <= req_kind_e'(req_kind);
          aonly_q <= addr_only;
          stop_q  <= stop;
          addr_q  <= req_addr;
          len_q   <= req_len;
          cap_q   <= buf_cap;
          if (too_long) begin
            done_q <= 1'b1; result_q <= R_TOOLONG; rx_q <= '0;
          end else begin
            st <= ST_SEND; idx_q <= '0; tries_q <= '0;
          end
        end
        ST_SEND: if (tx_ready) begin
          if (frame_last) st <= ST_RESP;
          else            idx_q <= idx_q + 1'b1;
        end
        ST_RESP: begin
          if (ev_finish) begin
            st <= ST_IDLE; done_q <= 1'b1; result_q <= ev_res; rx_q <= ev_cnt;
          end else if (ev_resend) begin
            st <= ST_SEND; idx_q <= '0; tries_q <= tries_q + 1'b1;
          end else if (ev_wait) begin
            st <= ST_WAIT; tries_q <= tries_q + 1'b1;
          end
        end
        default: if (timer_expire) begin
          st <= ST_SEND; idx_q <= '0;
        end
      endcase
    end
  end

  assign tx_valid = (st == ST_SEND);
  assign tx_last  = tx_valid && frame_last;
  assign done     = done_q;
  assign result   = result_q;
  assign rx_count = rx_q;
endmodule

// File: rtl/aux_req_chk.sv
module aux_req_chk #(
  parameter int MAX_TRIES = 4,
  parameter int LEN_W     = 5,
  parameter int TRY_W     = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             too_long,
  input logic             in_idle,
  input logic             in_resp,
  input logic             in_wait,
  input logic             final_try,
  input logic             rsp_valid,
  input logic [1:0]       rsp_status,
  input logic [7:0]       rsp_reply,
  input logic             tx_valid,
  input logic             tx_last,
  input logic             done,
  input logic [2:0]       result,
  input logic [LEN_W-1:0] rx_count,
  input logic [LEN_W-1:0] cap_q,
  input logic [TRY_W-1:0] tries_q
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle && start && too_long |=> done && result == 3'd5 && !tx_valid);

  // R4
  busy_resend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_resp && rsp_valid && rsp_status == 2'd2 && !final_try |=> tx_valid);

  // R4
  timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_resp && rsp_valid && rsp_status == 2'd1 |=> done && result == 3'd1);

  // R5
  native_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_resp && rsp_valid && rsp_status == 2'd0 && rsp_reply[5:4] == 2'd1
      |=> done && result == 3'd3);

  // R7
  wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> !tx_valid && !done);

  // R8
  tries_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tries_q) < MAX_TRIES);

  // R9
  clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> rx_count <= cap_q);

  // R2
  last_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);
endmodule

bind aux_req_framer aux_req_chk #(
  .MAX_TRIES(MAX_TRIES), .LEN_W(LEN_W), .TRY_W(TRY_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .too_long(too_long),
  .in_idle(in_idle), .in_resp(in_resp), .in_wait(in_wait),
  .final_try(final_try), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
  .rsp_reply(rsp_reply), .tx_valid(tx_valid), .tx_last(tx_last),
  .done(done), .result(result), .rx_count(rx_count), .cap_q(cap_q),
  .tries_q(tries_q)
);

// File: tb/sim_aux_req_framer.sv
module sim_aux_req_framer;
  localparam int PERIOD = 10;
  localparam int CLK_HZ = 25_000;
  localparam int WAITC  = CLK_HZ / 2500;
  localparam int NV     = 24;

  typedef struct packed {
    logic [1:0]  kind;
    logic        aonly;
    logic        stp;
    logic [19:0] addr;
    logic [4:0]  len;
    logic [4:0]  cap;
    logic [2:0]  nresp;
    logic [59:0] rsp;
    logic [2:0]  est;
    logic [4:0]  ecnt;
  } vec_t;

  function automatic logic [14:0] rs(int st, int rep, int ln);
    return {st[1:0], rep[7:0], ln[4:0]};
  endfunction
  function automatic logic [59:0] p4(logic [14:0] a, logic [14:0] b, logic [14:0] c, logic [14:0] d);
    return {d, c, b, a};
  endfunction

  localparam logic [14:0] Z  = 15'd0;
  localparam logic [14:0] BZ = {2'd2, 8'h00, 5'd0};
  localparam logic [14:0] DF = {2'd0, 8'h20, 5'd0};

  localparam vec_t VECS [NV] = '{
    '{2'd0,1'b0,1'b1,20'h00102,5'd2, 5'd16,3'd1,p4(rs(0,0,0),Z,Z,Z),3'd0,5'd0},
    '{2'd1,1'b0,1'b1,20'h00202,5'd6, 5'd16,3'd1,p4(rs(0,0,6),Z,Z,Z),3'd0,5'd6},
    '{2'd1,1'b0,1'b1,20'hA1234,5'd8, 5'd3, 3'd1,p4(rs(0,0,8),Z,Z,Z),3'd0,5'd3},
    '{2'd1,1'b0,1'b1,20'h00010,5'd1, 5'd4, 3'd1,p4(rs(0,0,0),Z,Z,Z),3'd4,5'd0},
    '{2'd0,1'b0,1'b1,20'h00300,5'd17,5'd16,3'd0,p4(Z,Z,Z,Z),3'd5,5'd0},
    '{2'd0,1'b0,1'b1,20'h00400,5'd16,5'd16,3'd1,p4(rs(0,0,0),Z,Z,Z),3'd0,5'd0},
    '{2'd2,1'b0,1'b1,20'h00050,5'd1, 5'd1, 3'd1,p4(rs(0,0,0),Z,Z,Z),3'd0,5'd0},
    '{2'd3,1'b0,1'b0,20'h00050,5'd1, 5'd1, 3'd1,p4(rs(0,0,1),Z,Z,Z),3'd0,5'd1},
    '{2'd3,1'b1,1'b1,20'h00050,5'd1, 5'd1, 3'd1,p4(rs(0,0,0),Z,Z,Z),3'd0,5'd0},
    '{2'd1,1'b0,1'b1,20'h00000,5'd4, 5'd16,3'd3,p4(BZ,BZ,rs(0,0,4),Z),3'd0,5'd4},
    '{2'd1,1'b0,1'b1,20'h00000,5'd4, 5'd16,3'd4,p4(BZ,BZ,BZ,BZ),3'd6,5'd0},
    '{2'd1,1'b0,1'b1,20'h00020,5'd4, 5'd16,3'd2,p4(DF,rs(0,0,4),Z,Z),3'd0,5'd4},
    '{2'd3,1'b0,1'b1,20'h00050,5'd1, 5'd1, 3'd2,p4(rs(0,8'h80,0),rs(0,0,1),Z,Z),3'd0,5'd1},
    '{2'd0,1'b0,1'b1,20'h00600,5'd1, 5'd16,3'd1,p4(rs(0,8'h10,0),Z,Z,Z),3'd3,5'd0},
    '{2'd0,1'b0,1'b1,20'h00600,5'd1, 5'd16,3'd1,p4(rs(0,8'h30,0),Z,Z,Z),3'd3,5'd0},
    '{2'd2,1'b0,1'b1,20'h00050,5'd1, 5'd1, 3'd1,p4(rs(0,8'h40,0),Z,Z,Z),3'd3,5'd0},
    '{2'd3,1'b0,1'b1,20'h00050,5'd1, 5'd1, 3'd1,p4(rs(0,8'hC0,0),Z,Z,Z),3'd3,5'd0},
    '{2'd1,1'b0,1'b1,20'h00700,5'd2, 5'd16,3'd1,p4(rs(1,0,0),Z,Z,Z),3'd1,5'd0},
    '{2'd1,1'b0,1'b1,20'h00700,5'd2, 5'd16,3'd1,p4(rs(3,0,0),Z,Z,Z),3'd2,5'd0},
    '{2'd1,1'b0,1'b1,20'h00800,5'd2, 5'd16,3'd4,p4(DF,DF,DF,DF),3'd6,5'd0},
    '{2'd1,1'b0,1'b1,20'h00900,5'd2, 5'd16,3'd1,p4(rs(0,8'h40,2),Z,Z,Z),3'd0,5'd2},
    '{2'd3,1'b0,1'b1,20'h00050,5'd1, 5'd1, 3'd2,p4(rs(0,8'h60,0),rs(0,0,1),Z,Z),3'd0,5'd1},
    '{2'd0,1'b0,1'b1,20'h00A00,5'd0, 5'd16,3'd0,p4(Z,Z,Z,Z),3'd5,5'd0},
    '{2'd1,1'b0,1'b1,20'h00B00,5'd3, 5'd0, 3'd1,p4(rs(0,0,5),Z,Z,Z),3'd0,5'd0}
  };
  localparam string TAGS [NV] = '{
    "R1","R2","R9","R9","R3","R2","R2","R1","R2","R4","R8","R7",
    "R7","R5","R5","R6","R6","R4","R4","R8","R6","R6","R3","R9"
  };

  logic         clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0]   req_kind = '0;
  logic         addr_only = 1'b0, stop = 1'b1;
  logic [19:0]  req_addr = '0;
  logic [4:0]   req_len = '0, buf_cap = '0, rsp_len = '0;
  logic [127:0] wr_data;
  logic         tx_valid, tx_last, tx_ready = 1'b1, rsp_valid = 1'b0, done;
  logic [7:0]   tx_byte, rsp_reply = '0;
  logic [1:0]   rsp_status = '0;
  logic [2:0]   result;
  logic [4:0]   rx_count;

  aux_req_framer #(.CLK_HZ(CLK_HZ)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .req_kind(req_kind),
    .addr_only(addr_only), .stop(stop), .req_addr(req_addr),
    .req_len(req_len), .buf_cap(buf_cap), .wr_data(wr_data),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_last(tx_last),
    .tx_ready(tx_ready), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .rsp_reply(rsp_reply), .rsp_len(rsp_len), .done(done),
    .result(result), .rx_count(rx_count)
  );

  always #(PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int pay(int k);
    return 8'hA0 + k;
  endfunction

  function automatic int exp_total(vec_t v);
    if (v.kind == 2'd0) return 4 + int'(v.len);
    if (v.kind == 2'd2) return v.aonly ? 4 : 5;
    return 4;
  endfunction

  function automatic int exp_byte(vec_t v, int i);
    int rd, cmd, ln;
    rd = int'(v.kind[0]);
    ln = int'(v.len);
    if (i == 0) return int'(v.addr[7:0]);
    if (i == 1) return int'(v.addr[15:8]);
    if (v.kind[1]) cmd = rd + (v.stp ? 0 : 4);
    else           cmd = 8 + rd;
    if (i == 2) return cmd * 16 + int'(v.addr[19:16]);
    if (i == 3) begin
      if (!v.kind[1]) return (exp_total(v) * 16 + ln - 1) % 256;
      if (v.aonly) return 48;
      return rd ? 64 : 80;
    end
    return pay(i - 4);
  endfunction

  task automatic run(input vec_t v, input string tag, input bit stall);
    int first [20];
    int n1, ntot, ri, lows, expl;
    bit pend, fin;
    logic [14:0] r;
    logic [2:0] got_st;
    logic [4:0] got_cnt;
    n1 = 0; ntot = 0; ri = 0; fin = 0; got_st = '0; got_cnt = '0;
    req_kind = v.kind; addr_only = v.aonly; stop = v.stp; req_addr = v.addr;
    req_len = v.len; buf_cap = v.cap; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 0; cyc < 3000 && !fin; cyc++) begin
      tx_ready = stall ? (cyc % 3 != 1) : 1'b1;
      if (done) begin
        fin = 1; got_st = result; got_cnt = rx_count;
      end else begin
        pend = 1'b0;
        if (tx_valid && tx_ready) begin
          if (ri == 0 && n1 < 20) begin first[n1] = int'(tx_byte); n1++; end
          ntot++;
          pend = tx_last;
        end
        @(negedge clk);
        if (pend) begin
          r = (ri < 4) ? v.rsp[ri*15 +: 15] : 15'd0;
          {rsp_status, rsp_reply, rsp_len} = r;
          rsp_valid = 1'b1;
          @(negedge clk);
          rsp_valid = 1'b0;
          lows = 0;
          while (!tx_valid && !done && lows < 1000) begin
            lows++;
            @(negedge clk);
          end
          if (ri < int'(v.nresp) - 1) begin
            expl = (r[14:13] == 2'd2) ? 0 : WAITC;
            // R4 busy resends at once, R7 deferral pause
            chk(lows == expl, {tag, " R7 idle cycles before retry"}, lows, expl);
          end
          ri++;
        end
      end
    end
    tx_ready = 1'b1;
    // R10 completion seen
    chk(fin, {tag, " R10 done"}, int'(fin), 1);
    chk(got_st == v.est, {tag, " result"}, int'(got_st), int'(v.est));
    chk(got_cnt == v.ecnt, {tag, " R9 rx_count"}, int'(got_cnt), int'(v.ecnt));
    // R8 attempts equal responses consumed
    chk(ri == int'(v.nresp), {tag, " R8 attempts"}, ri, int'(v.nresp));
    if (v.nresp != 0) begin
      chk(n1 == exp_total(v), {tag, " R2 frame size"}, n1, exp_total(v));
      chk(ntot == n1 * ri, {tag, " R2 bytes over attempts"}, ntot, n1 * ri);
      for (int i = 0; i < n1; i++)
        chk(first[i] == exp_byte(v, i), {tag, (i < 3) ? " R1 header byte" : " R2 frame byte"},
            first[i], exp_byte(v, i));
    end
    @(negedge clk);
    // R10 one-cycle pulse
    chk(!done, {tag, " R10 done falls"}, int'(done), 0);
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL R10: watchdog expired, actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 16; k++) wr_data[k*8 +: 8] = 8'(pay(k));
    @(negedge clk);
    // R11 during reset
    chk(!tx_valid && !done, "R11 in reset", int'({tx_valid, done}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tx_valid && !done, "R11 after reset", int'({tx_valid, done}), 0);
    for (int n = 0; n < NV; n++) run(VECS[n], TAGS[n], 1'b0);
    // R2 backpressure on the byte stream: long native write with stalls
    run(VECS[5], "R2 stalled", 1'b1);
    // R6 deferral inside an I2C access with stalls
    run(VECS[12], "R6 stalled", 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule